// File: doc/BRIEF.md
# Programmable Vertical Transfer Timer

This block paces vertical charge transfers for an image sensor. A free-running binary counter divides the input clock. A small range code picks one of the counter's upper stages as the transfer rate. Every time the picked stage goes from 0 to 1, a fixed three-step phase train is fired on two vertical phase outputs. The train is a pulse on phase one, then a pulse on phase two, then a second pulse on phase one. Timed gaps separate the pulses.

A range code of zero cuts the counter off from the trigger path. Software then starts each transfer itself with a strobe. When a train finishes, a single-cycle done pulse is raised so that a ready flag elsewhere can be set. While a train runs, the busy output is high, and any new trigger is dropped.

Top module: `vxfer_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `phi1`, `phi2`, `xfer_done` and `busy` are all 0, and the divider counter restarts from 0.
- R2: The divider is a 14-bit counter that advances by one on every clock. For a range code k from 1 to 7, the tap is counter bit 6+k. A periodic trigger occurs in any cycle where the tap is 1 and was 0 in the previous cycle. With a steady code, code 1 therefore triggers every 256 cycles and code 3 every 1024 cycles, and the full span across the codes is 64:1.
- R3: With range code 0, no periodic trigger ever occurs. Each cycle with `soft_strobe` high while idle is a trigger.
- R4: With a nonzero range code, `soft_strobe` has no effect.
- R5: A trigger accepted in cycle t makes `phi1` high for PULSE_CYC cycles starting at t+1. A gap of GAP_CYC cycles follows, then `phi2` is high for PULSE_CYC cycles. A second gap of GAP_CYC cycles follows, then `phi1` is high again for PULSE_CYC cycles.
- R6: `phi1` and `phi2` are never high in the same cycle.
- R7: `xfer_done` is high for exactly one cycle, which is the cycle right after the second `phi1` pulse ends.
- R8: `busy` is high from the first `phi1` cycle through the `xfer_done` cycle. Triggers during that time are dropped. With the strobe held high at code 0, trains therefore repeat every 3*PULSE_CYC+2*GAP_CYC+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that feeds the divider |
| rst | input | 1 | Synchronous active-high reset |
| range_code | input | 3 | Rate select: 0 selects software strobe, 1..7 select a divider tap |
| soft_strobe | input | 1 | Software transfer request, used only when the code is 0 |
| phi1 | output | 1 | Vertical phase one drive (two pulses per train) |
| phi2 | output | 1 | Vertical phase two drive (one pulse per train) |
| xfer_done | output | 1 | One-cycle completion pulse for setting the ready flag |
| busy | output | 1 | High while a phase train is in progress |

## Verification
The tap-edge assertion assumes that `range_code` is held steady across the cycle after a trigger. A code change can present a fresh 0-to-1 step on a different tap, and that step counts as a trigger. The stimulus changes the code only between measurement windows, and the reference model follows every code switch, including the immediate trigger it can cause. The assertion that the phases never collide assumes GAP_CYC is at least 1. The bench uses the default of 2.

// File: rtl/vxt_pkg.sv
package vxt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_V1_LEAD,
        ST_GAP_A,
        ST_V2,
        ST_GAP_B,
        ST_V1_TRAIL,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic phi1;
        logic phi2;
        logic done;
        logic busy;
    } phase_out_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vxt_ripple_div.sv
module vxt_ripple_div #(
    parameter int unsigned STAGES      = 14,
    parameter int unsigned RATE_STAGES = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [RATE_STAGES-1:0] taps
);
    logic [STAGES-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + 1'b1;
    end

    assign taps = count_q[STAGES-1 -: RATE_STAGES];

    // R2
    div_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_q == $past(count_q) + 1'b1);

endmodule

// File: rtl/vxt_trig_select.sv
module vxt_trig_select #(
    parameter int unsigned RATE_STAGES = 7,
    parameter int unsigned CODE_W      = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [RATE_STAGES-1:0] taps,
    input  logic [CODE_W-1:0]      range_code,
    input  logic                   soft_strobe,
    output logic                   trig
);
    logic [RATE_STAGES:0] cand;
    logic                 tap_sel;
    logic                 tap_prev_q;

    assign cand    = {taps, 1'b0};
    assign tap_sel = cand[range_code];

    always_ff @(posedge clk) begin
        if (rst) tap_prev_q <= 1'b0;
        else     tap_prev_q <= tap_sel;
    end

    always_comb begin
        if (range_code == '0) trig = soft_strobe;
        else                  trig = tap_sel & ~tap_prev_q;
    end

    // R2
    tick_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (range_code != '0 && trig) ##1 (range_code == $past(range_code)) |-> !trig);

endmodule

// File: rtl/vxt_phase_seq.sv
module vxt_phase_seq
    import vxt_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned GAP_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    output phase_out_t outs
);
    localparam int unsigned LONGEST = max2(PULSE_CYC, GAP_CYC);
    localparam int unsigned TMR_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             expired;

    assign expired = (tmr_q == '0);

    always_comb begin
        state_d = state_q;
        tmr_d   = expired ? '0 : tmr_q - 1'b1;
        case (state_q)
            ST_IDLE:     if (trig) begin state_d = ST_V1_LEAD;  tmr_d = PULSE_LD; end
            ST_V1_LEAD:  if (expired) begin state_d = ST_GAP_A;    tmr_d = GAP_LD;   end
            ST_GAP_A:    if (expired) begin state_d = ST_V2;       tmr_d = PULSE_LD; end
            ST_V2:       if (expired) begin state_d = ST_GAP_B;    tmr_d = GAP_LD;   end
            ST_GAP_B:    if (expired) begin state_d = ST_V1_TRAIL; tmr_d = PULSE_LD; end
            ST_V1_TRAIL: if (expired) begin state_d = ST_DONE;     tmr_d = '0;       end
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        outs.phi1 = (state_q == ST_V1_LEAD) || (state_q == ST_V1_TRAIL);
        outs.phi2 = (state_q == ST_V2);
        outs.done = (state_q == ST_DONE);
        outs.busy = (state_q != ST_IDLE);
    end

    // R6
    phase_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(outs.phi1 && outs.phi2));

    // R5
    phi2_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.phi2) |-> !$past(outs.phi1));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        outs.done |=> !outs.done);

    // R7
    done_after_phi1_chk: assert property (@(posedge clk) disable iff (rst)
        outs.done |-> $past(outs.phi1));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (outs.busy && !outs.done) |=> outs.busy);

endmodule

// File: rtl/vxfer_timer.sv
module vxfer_timer
    import vxt_pkg::*;
#(
    parameter int unsigned STAGES      = 14,
    parameter int unsigned RATE_STAGES = 7,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned GAP_CYC     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] range_code,
    input  logic       soft_strobe,
    output logic       phi1,
    output logic       phi2,
    output logic       xfer_done,
    output logic       busy
);
    localparam int unsigned CODE_W = $clog2(RATE_STAGES + 1);

    logic [RATE_STAGES-1:0] taps;
    logic                   trig;
    phase_out_t             outs;

    vxt_ripple_div #(
        .STAGES      (STAGES),
        .RATE_STAGES (RATE_STAGES)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .taps (taps)
    );

    vxt_trig_select #(
        .RATE_STAGES (RATE_STAGES),
        .CODE_W      (CODE_W)
    ) u_trig (
        .clk         (clk),
        .rst         (rst),
        .taps        (taps),
        .range_code  (CODE_W'(range_code)),
        .soft_strobe (soft_strobe),
        .trig        (trig)
    );

    vxt_phase_seq #(
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .outs (outs)
    );

    assign phi1      = outs.phi1;
    assign phi2      = outs.phi2;
    assign xfer_done = outs.done;
    assign busy      = outs.busy;

endmodule

// File: tb/vxfer_timer_tb_top.sv
module vxfer_timer_tb_top;
    localparam int P = 4;
    localparam int G = 2;
    localparam int L = 3*P + 2*G + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] range_code = 3'd0;
    logic       soft_strobe = 1'b0;
    logic       phi1, phi2, xfer_done, busy;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // model state
    int mcnt = 0;
    int mprev = 0;
    int mpos = 0;

    // monitor state
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int prev_rise = 0;
    bit busy_q = 1'b0;
    int phi1_cyc = 0;
    int phi2_cyc = 0;
    int done_cyc = 0;

    always #5 clk = ~clk;

    vxfer_timer #(.PULSE_CYC(P), .GAP_CYC(G)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .range_code  (range_code),
        .soft_strobe (soft_strobe),
        .phi1        (phi1),
        .phi2        (phi2),
        .xfer_done   (xfer_done),
        .busy        (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        int sel;
        int trg;
        if (rst) begin
            mcnt = 0; mprev = 0; mpos = 0;
        end else begin
            sel = (range_code == 0) ? 0 : ((mcnt >> (6 + int'(range_code))) & 1);
            trg = (range_code == 0) ? int'(soft_strobe) : ((sel == 1 && mprev == 0) ? 1 : 0);
            mprev = sel;
            mcnt = (mcnt + 1) % 16384;
            if (mpos == 0) mpos = trg ? 1 : 0;
            else           mpos = (mpos == L) ? 0 : mpos + 1;
        end
    end

    // per-cycle comparison and monitors
    always @(negedge clk) begin
        int e1, e2, ed, eb;
        cyc++;
        e1 = ((mpos >= 1 && mpos <= P) || (mpos >= 2*P+2*G+1 && mpos <= 3*P+2*G)) ? 1 : 0;
        e2 = (mpos >= P+G+1 && mpos <= 2*P+G) ? 1 : 0;
        ed = (mpos == L) ? 1 : 0;
        eb = (mpos != 0) ? 1 : 0;
        chk(int'(phi1) == e1, "R5 phi1", int'(phi1), e1);
        chk(int'(phi2) == e2, "R5 phi2", int'(phi2), e2);
        chk(int'(xfer_done) == ed, "R7 xfer_done", int'(xfer_done), ed);
        chk(int'(busy) == eb, "R8 busy", int'(busy), eb);
        chk(!(phi1 && phi2), "R6 overlap", int'(phi1 && phi2), 0);
        if (busy && !busy_q) begin
            rises++;
            prev_rise = last_rise;
            last_rise = cyc;
        end
        busy_q = busy;
        if (phi1) phi1_cyc++;
        if (phi2) phi2_cyc++;
        if (xfer_done) done_cyc++;
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rises(input int n, input int limit);
        int target;
        target = rises + n;
        for (int i = 0; i < limit && rises < target; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int r0;
        wait_cyc(3);
        // R1 reset state
        chk({phi1, phi2, xfer_done, busy} == 4'b0, "R1 outputs in reset", int'({phi1, phi2, xfer_done, busy}), 0);
        rst = 1'b0;
        wait_cyc(1);
        chk({phi1, phi2, xfer_done, busy} == 4'b0, "R1 outputs after reset", int'({phi1, phi2, xfer_done, busy}), 0);
        wait_cyc(4);

        // R3 single software strobe, R5/R7 shape counts
        phi1_cyc = 0; phi2_cyc = 0; done_cyc = 0;
        r0 = rises;
        soft_strobe = 1'b1;
        wait_cyc(1);
        soft_strobe = 1'b0;
        wait_cyc(L + 5);
        chk(rises == r0 + 1, "R3 strobe starts train", rises - r0, 1);
        chk(phi1_cyc == 2*P, "R5 phi1 cycles per train", phi1_cyc, 2*P);
        chk(phi2_cyc == P, "R5 phi2 cycles per train", phi2_cyc, P);
        chk(done_cyc == 1, "R7 done pulses per train", done_cyc, 1);

        // R3 code 0 without strobe: no periodic trains
        r0 = rises;
        wait_cyc(600);
        chk(rises == r0, "R3 no periodic trigger at code 0", rises - r0, 0);

        // R8 strobe held: retriggers dropped while busy
        soft_strobe = 1'b1;
        wait_cyc(3*(L+1) + 2);
        soft_strobe = 1'b0;
        chk(last_rise - prev_rise == L + 1, "R8 held strobe repeat interval", last_rise - prev_rise, L + 1);
        wait_cyc(L + 2);

        // R4 strobe ignored with nonzero code (bit 13 still low)
        range_code = 3'd7;
        r0 = rises;
        soft_strobe = 1'b1;
        wait_cyc(200);
        soft_strobe = 1'b0;
        chk(rises == r0, "R4 strobe ignored at code 7", rises - r0, 0);

        // R2 code 7 fires on top stage
        wait_rises(1, 9000);
        chk(rises == r0 + 1, "R2 code 7 trigger", rises - r0, 1);
        wait_cyc(L + 2);

        // R2 code 1 period
        range_code = 3'd1;
        wait_rises(3, 1000);
        chk(last_rise - prev_rise == 256, "R2 code 1 period", last_rise - prev_rise, 256);

        // R2 code 3 period
        range_code = 3'd3;
        wait_rises(3, 4000);
        chk(last_rise - prev_rise == 1024, "R2 code 3 period", last_rise - prev_rise, 1024);

        // R1 reset mid-operation clears outputs
        range_code = 3'd0;
        soft_strobe = 1'b1;
        wait_cyc(3);
        soft_strobe = 1'b0;
        rst = 1'b1;
        wait_cyc(2);
        chk({phi1, phi2, xfer_done, busy} == 4'b0, "R1 reset aborts train", int'({phi1, phi2, xfer_done, busy}), 0);
        rst = 1'b0;
        wait_cyc(5);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule